// File: doc/BRIEF.md
# Floppy Controller Status and Interrupt Unit

This block sits beside the command sequencers of a floppy disk controller. It keeps the busy flag, decides which status layout applies (head positioning or data transfer) from the last accepted command, and merges the sequencer flags with synchronised drive levels into the 8-bit status value the host reads. When the sequencer signals completion, it raises the interrupt request.

It also carries out the force-interrupt command, opcode `1101` in command bits 7..4. The low nibble is a condition mask:

- bit 3: interrupt at once.
- bit 2: interrupt on each index pulse.
- bit 1: interrupt when the drive drops out of ready.
- bit 0: interrupt when the drive becomes ready.

A force-interrupt that arrives while a command runs ends that command with a one-cycle abort strobe. This is the only way a multi-sector transfer ends.

Drive inputs are asynchronous. Each passes a synchroniser first. Index and ready are then edge-detected, so one input edge gives exactly one event. The interrupt request drops when the host reads status or writes a new command.

Top module: `fdc_stat_irq`

## Requirements
- R1: After reset, busy, interrupt request and abort are low and the layout is positioning. With all inputs low, status reads 0x00.
- R2: Writing a command other than force-interrupt while idle sets busy (status bit 0) on the next cycle. Such writes are ignored while busy, so a multi-sector command stays busy until aborted. A force-interrupt never sets busy.
- R3: A completion pulse from the sequencer while busy clears busy and raises the interrupt request on the next cycle.
- R4: A force-interrupt written while busy gives a single-cycle abort pulse and clears busy on the next cycle, keeping the data layout. Written while idle it gives no abort.
- R5: A force-interrupt with mask bit 3 set raises the interrupt request on the next cycle.
- R6: With mask bit 2 armed, each rising edge of the index input raises the interrupt request three cycles after the input changes. A held-high index gives only one event.
- R7: With mask bit 1 armed, a falling edge of ready raises the interrupt request, and a rising edge does not.
- R8: With mask bit 0 armed, a rising edge of ready raises the interrupt request, and a falling edge does not.
- R9: A force-interrupt with a zero mask raises no interrupt and disarms any earlier condition.
- R10: A status read lowers the interrupt request on the next cycle, unless a new interrupt event occurs in that same cycle. In that case the request stays high.
- R11: Any accepted command write lowers the interrupt request. The exception is a force-interrupt with mask bit 3, which sets it.
- R12: In the positioning layout (accepted command bit 7 = 0, or a force-interrupt while idle), the status bits are:
  - bit 6 reads 0
  - bit 5 is spin-up done
  - bit 2 is track 0
- R13: In the data layout (accepted command bit 7 = 1, not force-interrupt), the status bits are:
  - bit 6 is write-protect
  - bit 5 is deleted data
  - bit 2 is lost data
- R14: In both layouts, the status bits are:
  - bit 7 is motor on
  - bit 4 is record not found
  - bit 3 is CRC error
  - bit 1 is data request
  - bit 0 is busy

  Drive levels appear two cycles after the input changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wr | input | 1 | Command write strobe |
| cmd_byte | input | 8 | Command value written |
| stat_rd | input | 1 | Status read strobe |
| seq_done | input | 1 | Sequencer completion pulse |
| seq_spin_done | input | 1 | Motor spin-up finished |
| seq_deleted | input | 1 | Deleted data mark seen |
| seq_rec_nf | input | 1 | Record not found |
| seq_crc_err | input | 1 | CRC error |
| seq_lost | input | 1 | Lost data |
| seq_drq | input | 1 | Data request |
| drv_index | input | 1 | Index pulse from drive (asynchronous) |
| drv_ready | input | 1 | Drive ready (asynchronous) |
| drv_wprot | input | 1 | Write-protect (asynchronous) |
| drv_trk0 | input | 1 | Head at track 0 (asynchronous) |
| drv_motor | input | 1 | Motor running (asynchronous) |
| status | output | 8 | Assembled status value |
| irq | output | 1 | Interrupt request |
| abort | output | 1 | One-cycle abort strobe to the sequencers |

## Verification
The bench goes after several corner cases:

- Layout switching. A design that keyed the layout off the live command byte would show write-protect after an idle force-interrupt, or would switch layout on a write ignored during busy.
- Edge events. It holds index high across a status read; a level-triggered detector would re-raise the interrupt at once. It drives ready in the direction that must not trigger, so a swapped polarity shows up.
- Clear and set in the same cycle. It lines up a status read with an index event; a design that gave the clear priority would lose that interrupt.
- Zero mask. A zero-mask force-interrupt must abort without raising an interrupt and must disarm the earlier mask.

// File: rtl/fdc_stat_pkg.sv
package fdc_stat_pkg;

    localparam int CMD_W = 8;
    localparam logic [3:0] FI_OPCODE = 4'hD;

    localparam int DRV_W  = 5;
    localparam int IDX_B  = 0;
    localparam int RDY_B  = 1;
    localparam int WP_B   = 2;
    localparam int TK0_B  = 3;
    localparam int MOT_B  = 4;

    typedef enum logic {
        FMT_POS  = 1'b0,
        FMT_DATA = 1'b1
    } stat_fmt_e;

    typedef struct packed {
        logic spin_done;
        logic deleted;
        logic rec_nf;
        logic crc_err;
        logic lost;
        logic drq;
    } seq_flags_t;

    typedef struct packed {
        logic motor;
        logic wprot;
        logic trk0;
    } drv_lvl_t;

    typedef struct packed {
        logic immediate;
        logic on_index;
        logic on_unready;
        logic on_ready;
    } fi_mask_t;

    function automatic logic is_force_int(input logic [CMD_W-1:0] c);
        return c[CMD_W-1 -: 4] == FI_OPCODE;
    endfunction

    function automatic stat_fmt_e fmt_of(input logic [CMD_W-1:0] c);
        return c[CMD_W-1] ? FMT_DATA : FMT_POS;
    endfunction

endpackage

// File: rtl/fdc_sync.sv
module fdc_sync #(
    parameter int WIDTH  = 5,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) chain <= '0;
            else     chain <= {chain[STAGES-2:0], din[g]};
        end
        assign dout[g] = chain[STAGES-1];
    end
endmodule

// File: rtl/fdc_irq_ctrl.sv
module fdc_irq_ctrl
    import fdc_stat_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_wr,
    input  logic [CMD_W-1:0] cmd_byte,
    input  logic             stat_rd,
    input  logic             seq_done,
    input  logic             idx_lvl,
    input  logic             rdy_lvl,
    output logic             busy,
    output stat_fmt_e        fmt,
    output logic             irq,
    output logic             abort
);
    fi_mask_t mask;
    logic     idx_prev, rdy_prev;
    logic     idx_rise, rdy_rise, rdy_fall;
    logic     fi, accept, done_ok, evt, clr;
    fi_mask_t new_mask;

    assign idx_rise = idx_lvl & ~idx_prev;
    assign rdy_rise = rdy_lvl & ~rdy_prev;
    assign rdy_fall = ~rdy_lvl & rdy_prev;

    assign fi       = is_force_int(cmd_byte);
    assign accept   = cmd_wr & (fi | ~busy);
    assign done_ok  = seq_done & busy & ~accept;
    assign new_mask = fi_mask_t'(cmd_byte[3:0]);

    always_comb begin
        evt = done_ok;
        if (accept) begin
            evt = evt | (fi & new_mask.immediate);
        end else begin
            evt = evt | (mask.on_index & idx_rise)
                      | (mask.on_unready & rdy_fall)
                      | (mask.on_ready & rdy_rise);
        end
        clr = stat_rd | accept;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_prev <= 1'b0;
            rdy_prev <= 1'b0;
            busy     <= 1'b0;
            fmt      <= FMT_POS;
            mask     <= '0;
            irq      <= 1'b0;
            abort    <= 1'b0;
        end else begin
            idx_prev <= idx_lvl;
            rdy_prev <= rdy_lvl;
            abort    <= accept & fi & busy;
            if (accept && fi) begin
                mask <= new_mask;
                busy <= 1'b0;
                if (!busy) fmt <= FMT_POS;
            end else if (accept) begin
                mask <= '0;
                busy <= 1'b1;
                fmt  <= fmt_of(cmd_byte);
            end else if (done_ok) begin
                busy <= 1'b0;
            end
            if (evt)      irq <= 1'b1;
            else if (clr) irq <= 1'b0;
        end
    end
endmodule

// File: rtl/fdc_status_mux.sv
module fdc_status_mux
    import fdc_stat_pkg::*;
(
    input  stat_fmt_e   fmt,
    input  logic        busy,
    input  seq_flags_t  flags,
    input  drv_lvl_t    drv,
    output logic [7:0]  status
);
    always_comb begin
        status[7] = drv.motor;
        status[4] = flags.rec_nf;
        status[3] = flags.crc_err;
        status[1] = flags.drq;
        status[0] = busy;
        case (fmt)
            FMT_DATA: begin
                status[6] = drv.wprot;
                status[5] = flags.deleted;
                status[2] = flags.lost;
            end
            default: begin
                status[6] = 1'b0;
                status[5] = flags.spin_done;
                status[2] = drv.trk0;
            end
        endcase
    end
endmodule

// File: rtl/fdc_stat_irq.sv
module fdc_stat_irq
    import fdc_stat_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cmd_wr,
    input  logic [7:0] cmd_byte,
    input  logic       stat_rd,
    input  logic       seq_done,
    input  logic       seq_spin_done,
    input  logic       seq_deleted,
    input  logic       seq_rec_nf,
    input  logic       seq_crc_err,
    input  logic       seq_lost,
    input  logic       seq_drq,
    input  logic       drv_index,
    input  logic       drv_ready,
    input  logic       drv_wprot,
    input  logic       drv_trk0,
    input  logic       drv_motor,
    output logic [7:0] status,
    output logic       irq,
    output logic       abort
);
    logic [DRV_W-1:0] drv_raw, drv_syn;
    seq_flags_t       flags;
    drv_lvl_t         lvl;
    stat_fmt_e        fmt;
    logic             busy;

    always_comb begin
        drv_raw        = '0;
        drv_raw[IDX_B] = drv_index;
        drv_raw[RDY_B] = drv_ready;
        drv_raw[WP_B]  = drv_wprot;
        drv_raw[TK0_B] = drv_trk0;
        drv_raw[MOT_B] = drv_motor;
    end

    assign flags = '{spin_done: seq_spin_done, deleted: seq_deleted,
                     rec_nf: seq_rec_nf, crc_err: seq_crc_err,
                     lost: seq_lost, drq: seq_drq};
    assign lvl   = '{motor: drv_syn[MOT_B], wprot: drv_syn[WP_B],
                     trk0: drv_syn[TK0_B]};

    fdc_sync #(.WIDTH(DRV_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (drv_raw),
        .dout (drv_syn)
    );

    fdc_irq_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .cmd_wr   (cmd_wr),
        .cmd_byte (cmd_byte),
        .stat_rd  (stat_rd),
        .seq_done (seq_done),
        .idx_lvl  (drv_syn[IDX_B]),
        .rdy_lvl  (drv_syn[RDY_B]),
        .busy     (busy),
        .fmt      (fmt),
        .irq      (irq),
        .abort    (abort)
    );

    fdc_status_mux u_mux (
        .fmt    (fmt),
        .busy   (busy),
        .flags  (flags),
        .drv    (lvl),
        .status (status)
    );
endmodule

// File: rtl/fdc_stat_irq_chk.sv
module fdc_stat_irq_chk (
    input logic       clk,
    input logic       rst,
    input logic       cmd_wr,
    input logic [7:0] cmd_byte,
    input logic       seq_done,
    input logic [7:0] status,
    input logic       irq,
    input logic       abort
);
    logic fi_cmd;
    assign fi_cmd = cmd_byte[7:4] == 4'hD;

    p_busy_set_r2: assert property (@(posedge clk) disable iff (rst)
        cmd_wr && !fi_cmd && !status[0] |=> status[0]);

    p_fi_no_busy_r2: assert property (@(posedge clk) disable iff (rst)
        cmd_wr && fi_cmd && !status[0] |=> !status[0]);

    p_done_irq_r3: assert property (@(posedge clk) disable iff (rst)
        seq_done && status[0] && !cmd_wr |=> irq && !status[0]);

    p_abort_single_r4: assert property (@(posedge clk) disable iff (rst)
        abort |=> !abort);

    p_abort_idle_r4: assert property (@(posedge clk) disable iff (rst)
        abort |-> !status[0]);

    p_idle_fi_no_abort_r4: assert property (@(posedge clk) disable iff (rst)
        cmd_wr && fi_cmd && !status[0] |=> !abort);

    p_immediate_r5: assert property (@(posedge clk) disable iff (rst)
        cmd_wr && fi_cmd && cmd_byte[3] |=> irq);

    p_cmd_clears_r11: assert property (@(posedge clk) disable iff (rst)
        cmd_wr && !fi_cmd && !status[0] |=> !irq);
endmodule

bind fdc_stat_irq fdc_stat_irq_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .cmd_wr   (cmd_wr),
    .cmd_byte (cmd_byte),
    .seq_done (seq_done),
    .status   (status),
    .irq      (irq),
    .abort    (abort)
);

// File: tb/sim_fdc_stat_irq.sv
`timescale 1ns/1ps
module sim_fdc_stat_irq;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cmd_wr = 1'b0, stat_rd = 1'b0, seq_done = 1'b0;
    logic [7:0] cmd_byte = 8'h00;
    logic [5:0] sf = '0;
    logic [2:0] dv = '0;
    logic drv_index = 1'b0, drv_ready = 1'b0;
    logic [7:0] status;
    logic irq, abort;
    int n_cmp = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    fdc_stat_irq u0 (
        .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .cmd_byte(cmd_byte),
        .stat_rd(stat_rd), .seq_done(seq_done),
        .seq_spin_done(sf[5]), .seq_deleted(sf[4]), .seq_rec_nf(sf[3]),
        .seq_crc_err(sf[2]), .seq_lost(sf[1]), .seq_drq(sf[0]),
        .drv_index(drv_index), .drv_ready(drv_ready),
        .drv_wprot(dv[1]), .drv_trk0(dv[0]), .drv_motor(dv[2]),
        .status(status), .irq(irq), .abort(abort)
    );

    typedef struct packed {
        logic [7:0] cmd;
        logic [5:0] seqf;
        logic [2:0] drv;
        logic [7:0] exp;
    } vec_t;

    // seqf = {spin, deleted, rnf, crc, lost, drq}; drv = {motor, wprot, trk0}
    localparam vec_t VEC [6] = '{
        '{8'h00, 6'b100000, 3'b111, 8'hA5},
        '{8'h10, 6'b011010, 3'b010, 8'h11},
        '{8'h80, 6'b010101, 3'b011, 8'h6B},
        '{8'hA0, 6'b101010, 3'b100, 8'h95},
        '{8'hE0, 6'b111111, 3'b111, 8'hFF},
        '{8'h40, 6'b111111, 3'b010, 8'h3B}
    };

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] c);
        cmd_byte = c; cmd_wr = 1'b1; step(1); cmd_wr = 1'b0;
    endtask

    task automatic rd();
        stat_rd = 1'b1; step(1); stat_rd = 1'b0;
    endtask

    task automatic done_p();
        seq_done = 1'b1; step(1); seq_done = 1'b0;
    endtask

    task automatic chk(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        step(3);
        rst = 1'b0;
        step(1);
        chk("R1", "status", status, 8'h00);
        chk("R1", "irq", {7'd0, irq}, 8'h00);
        chk("R1", "abort", {7'd0, abort}, 8'h00);

        // table: layouts R12 R13 R14, busy R2, completion R3, read clear R10
        for (int i = 0; i < 6; i++) begin
            sf = VEC[i].seqf;
            dv = VEC[i].drv;
            step(2);
            wr(VEC[i].cmd);
            chk("R14", $sformatf("vec%0d status", i), status, VEC[i].exp);
            done_p();
            chk("R3", $sformatf("vec%0d irq", i), {7'd0, irq}, 8'h01);
            chk("R3", $sformatf("vec%0d busy", i), {7'd0, status[0]}, 8'h00);
            rd();
            chk("R10", $sformatf("vec%0d irq", i), {7'd0, irq}, 8'h00);
        end

        sf = '0; dv = 3'b010; step(3);
        // multi-sector read stays busy; later write ignored (R2)
        wr(8'h90);
        step(20);
        chk("R2", "multi busy", status, 8'h41);
        wr(8'h00);
        chk("R2", "ignored write", status, 8'h41);

        // zero-mask abort (R4, R9)
        wr(8'hD0);
        chk("R4", "abort pulse", {7'd0, abort}, 8'h01);
        chk("R4", "status after abort", status, 8'h40);
        step(1);
        chk("R4", "abort one cycle", {7'd0, abort}, 8'h00);
        chk("R9", "no irq", {7'd0, irq}, 8'h00);

        // idle force interrupt: no abort, positioning layout (R4, R12)
        wr(8'hD0);
        chk("R4", "idle no abort", {7'd0, abort}, 8'h00);
        chk("R12", "layout after idle fi", status, 8'h00);

        // immediate (R5), read clear (R10), command clear (R11)
        wr(8'hD8);
        chk("R5", "immediate irq", {7'd0, irq}, 8'h01);
        rd();
        chk("R10", "read clears", {7'd0, irq}, 8'h00);
        wr(8'hD8);
        wr(8'h00);
        chk("R11", "cmd clears irq", {7'd0, irq}, 8'h00);
        chk("R11", "cmd busy", status, 8'h01);
        done_p(); rd();

        // index pulses (R6)
        wr(8'hD4);
        drv_index = 1'b1; step(2);
        chk("R6", "sync latency", {7'd0, irq}, 8'h00);
        step(1);
        chk("R6", "first pulse", {7'd0, irq}, 8'h01);
        rd(); step(3);
        chk("R6", "held high one event", {7'd0, irq}, 8'h00);
        drv_index = 1'b0; step(4);
        drv_index = 1'b1; step(3);
        chk("R6", "second pulse", {7'd0, irq}, 8'h01);
        rd();
        drv_index = 1'b0; step(3);

        // read coinciding with event: set wins (R10)
        drv_index = 1'b1; step(2);
        stat_rd = 1'b1; step(1); stat_rd = 1'b0;
        chk("R10", "set wins over read", {7'd0, irq}, 8'h01);
        rd();
        drv_index = 1'b0; step(3);

        // zero mask disarms (R9)
        wr(8'hD0);
        drv_index = 1'b1; step(4);
        chk("R9", "disarmed index", {7'd0, irq}, 8'h00);
        drv_index = 1'b0; step(3);

        // ready falling (R7)
        wr(8'hD2);
        drv_ready = 1'b1; step(4);
        chk("R7", "rise ignored", {7'd0, irq}, 8'h00);
        drv_ready = 1'b0; step(3);
        chk("R7", "fall triggers", {7'd0, irq}, 8'h01);
        rd();

        // ready rising (R8)
        wr(8'hD1);
        drv_ready = 1'b1; step(3);
        chk("R8", "rise triggers", {7'd0, irq}, 8'h01);
        rd();
        drv_ready = 1'b0; step(4);
        chk("R8", "fall ignored", {7'd0, irq}, 8'h00);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule